// File: doc/BRIEF.md
# Pseudo-static memory standby and power-up sequencer

This block drives the standby-control pin (here called MODE) of a pseudo-static memory and holds the memory's chip select inactive whenever the memory must not see traffic. After power-good it keeps MODE low for a hold time, raises it, and then waits a settle time with chip select still held high. Only after that does it raise `ready`, which allows the host to start normal accesses. The host can ask for a light standby, where MODE stays high and chip select is parked high. It can also ask for a deep standby, where MODE is driven low and the memory keeps only part of its array, or none of it.

Leaving deep standby needs only a short wait when the retention setting keeps some data. When the setting keeps nothing, the wait is as long as the power-up settle time, and a `data_lost` flag goes up together with `ready` so that the host can discard any cached copy of the memory. The retention setting comes from outside: the mode register of the memory is programmed elsewhere. The setting is sampled when a standby request is accepted. All delays are cycle counts set by parameters.

Top module: `psram_pwr_seq`

## Requirements
- R1: During reset and while `pwr_good` is low, `mode_o`=0, `cs_force_hi`=1, `ready`=0, `data_lost`=0 and `dev_state`=0 (initialising).
- R2: Starting from the first clock edge that samples `pwr_good` high, `mode_o` stays low for exactly HOLD_CYC further cycles and then goes high.
- R3: `cs_force_hi` is 1 in the cycle before and in the cycle after every change of `mode_o`, except when the change is caused by a loss of power.
- R4: After `mode_o` rises during power-up, `ready` goes to 1 and `cs_force_hi` goes to 0 after exactly SETTLE_CYC cycles, with `dev_state`=1 (active).
- R5: When `stby_req` is sampled high while `ready`=1, on the next cycle `ready`=0 and `cs_force_hi`=1, and `mode_o` stays high for that one park cycle. `stby_deep` and `ret_sel` are sampled on that same edge.
- R6: Light standby (`stby_deep`=0) keeps `mode_o` high and `dev_state`=2. `ready` returns on the cycle after `stby_req` is sampled low.
- R7: Deep standby (`stby_deep`=1) drives `mode_o` low from the cycle after the park cycle. `dev_state` is 3 when data is kept and 4 when it is not.
- R8: For `ret_sel` 0, 1 or 2, releasing `stby_req` from deep standby raises `mode_o` on the next cycle and raises `ready` SHORT_CYC cycles later.
- R9: For `ret_sel`=3 (nothing kept), the exit wait is SETTLE_CYC cycles. `data_lost` rises together with `ready` and clears when the next standby entry starts.
- R10: Changes on `ret_sel` while in standby have no effect on `keep_top` or on the exit wait.
- R11: `keep_top` gives the highest retained word address for the latched setting. With ADDR_W=21 the values are 0x0FFFFF for setting 0, 0x07FFFF for setting 1, 0x03FFFF for setting 2, and 0 for setting 3.
- R12: A low `pwr_good` in any state returns the block to the R1 outputs on the next cycle and restarts the full power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_good | input | 1 | Memory supply is within range |
| stby_req | input | 1 | Host asks for standby while high |
| stby_deep | input | 1 | 1 selects deep standby (MODE low), 0 selects light standby |
| ret_sel | input | 2 | Retention setting programmed in the memory: 0 half, 1 quarter, 2 eighth, 3 none |
| mode_o | output | 1 | Level for the memory's MODE pin |
| cs_force_hi | output | 1 | Forces the memory chip select inactive |
| ready | output | 1 | Host traffic allowed |
| data_lost | output | 1 | Memory contents were lost by the last deep standby |
| dev_state | output | 3 | Memory state: 0 init, 1 active, 2 standby 1, 3 standby 2 kept, 4 standby 2 lost |
| keep_top | output | ADDR_W | Highest retained word address for the latched setting |

## Verification
Power-up is run first, and again after a power-good glitch in the middle of active operation. This separates the hold and settle counts and shows that power loss overrides everything else. Light standby and deep standby are each entered from the active state. Deep standby is run with every retention setting, so the short exit wait can be told apart from the long one, and only the setting that keeps nothing should raise the lost flag. One deep entry changes `ret_sel` during standby, to show that the setting was latched. A one-cycle request that is released during the park cycle shows that an entry, once started, still goes into standby.

// File: rtl/psram_pwr_pkg.sv
package psram_pwr_pkg;

  typedef enum logic [2:0] {
    SEQ_OFF, SEQ_HOLD, SEQ_SETTLE, SEQ_ACTIVE,
    SEQ_PARK, SEQ_LIGHT, SEQ_DEEP, SEQ_WAKE
  } seq_state_t;

  typedef enum logic [2:0] {
    DEV_INIT       = 3'd0,
    DEV_ACTIVE     = 3'd1,
    DEV_STBY1      = 3'd2,
    DEV_STBY2_KEEP = 3'd3,
    DEV_STBY2_LOST = 3'd4
  } dev_view_t;

  localparam logic [1:0] RET_NONE = 2'd3;

  // exit wait from deep standby, in cycles
  function automatic int unsigned wake_cycles(input logic [1:0] ret,
                                              input int unsigned short_c,
                                              input int unsigned settle_c);
    return (ret == RET_NONE) ? settle_c : short_c;
  endfunction

endpackage

// File: rtl/psram_pwr_timer.sv
module psram_pwr_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= load_val;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/psram_pwr_fsm.sv
module psram_pwr_fsm
  import psram_pwr_pkg::*;
#(
  parameter int HOLD_CYC   = 6250,
  parameter int SETTLE_CYC = 25000,
  parameter int SHORT_CYC  = 4,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_good,
  input  logic             stby_req,
  input  logic             stby_deep,
  input  logic [1:0]       ret_sel,
  input  logic             expired,
  output seq_state_t       state,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic [1:0]       ret_q,
  output logic             lost_q
);
  seq_state_t nxt;
  logic       deep_q;
  logic       ev_enter;
  logic       ev_wake_done;

  always_comb begin
    nxt      = state;
    load     = 1'b0;
    load_val = '0;
    if (!pwr_good) begin
      nxt = SEQ_OFF;
    end else begin
      case (state)
        SEQ_OFF: begin
          nxt = SEQ_HOLD; load = 1'b1; load_val = CNT_W'(HOLD_CYC - 1);
        end
        SEQ_HOLD: if (expired) begin
          nxt = SEQ_SETTLE; load = 1'b1; load_val = CNT_W'(SETTLE_CYC - 1);
        end
        SEQ_SETTLE: if (expired) nxt = SEQ_ACTIVE;
        SEQ_ACTIVE: if (stby_req) nxt = SEQ_PARK;
        SEQ_PARK:   nxt = deep_q ? SEQ_DEEP : SEQ_LIGHT;
        SEQ_LIGHT:  if (!stby_req) nxt = SEQ_ACTIVE;
        SEQ_DEEP: if (!stby_req) begin
          nxt = SEQ_WAKE; load = 1'b1;
          load_val = CNT_W'(wake_cycles(ret_q, SHORT_CYC, SETTLE_CYC) - 1);
        end
        SEQ_WAKE: if (expired) nxt = SEQ_ACTIVE;
        default:  nxt = SEQ_OFF;
      endcase
    end
  end

  assign ev_enter     = (state == SEQ_ACTIVE) && (nxt == SEQ_PARK);
  assign ev_wake_done = (state == SEQ_WAKE) && (nxt == SEQ_ACTIVE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SEQ_OFF;
      deep_q <= 1'b0;
      ret_q  <= 2'd0;
      lost_q <= 1'b0;
    end else begin
      state <= nxt;
      if (ev_enter) begin
        deep_q <= stby_deep;
        ret_q  <= ret_sel;
        lost_q <= 1'b0;
      end else if (ev_wake_done) begin
        lost_q <= (ret_q == RET_NONE);
      end else if (nxt == SEQ_OFF) begin
        lost_q <= 1'b0;
      end
    end
  end

  AST_ENTRY_LEAVES_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_ACTIVE && stby_req && pwr_good) |=> (state == SEQ_PARK)); // R5

  AST_PARK_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_PARK && pwr_good) |=> (state inside {SEQ_LIGHT, SEQ_DEEP})); // R7

endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq
  import psram_pwr_pkg::*;
#(
  parameter int ADDR_W     = 21,
  parameter int HOLD_CYC   = 6250,
  parameter int SETTLE_CYC = 25000,
  parameter int SHORT_CYC  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              stby_req,
  input  logic              stby_deep,
  input  logic [1:0]        ret_sel,
  output logic              mode_o,
  output logic              cs_force_hi,
  output logic              ready,
  output logic              data_lost,
  output logic [2:0]        dev_state,
  output logic [ADDR_W-1:0] keep_top
);
  localparam int MAX_HS = (HOLD_CYC > SETTLE_CYC) ? HOLD_CYC : SETTLE_CYC;
  localparam int MAX_C  = (MAX_HS > SHORT_CYC) ? MAX_HS : SHORT_CYC;
  localparam int CNT_W  = $clog2(MAX_C + 1);
  localparam logic [CNT_W:0] MH_SAT = (CNT_W + 1)'(SETTLE_CYC);

  function automatic logic [ADDR_W-1:0] keep_limit(input logic [1:0] r);
    logic [ADDR_W-1:0] one;
    one = ADDR_W'(1);
    if (r == RET_NONE) return '0;
    return (one << (ADDR_W - 1 - int'(r))) - one;
  endfunction

  seq_state_t       state;
  logic             t_load;
  logic [CNT_W-1:0] t_val;
  logic             t_expired;
  logic [1:0]       ret_q;
  logic             lost_q;
  logic [CNT_W:0]   mh_cnt;   // cycles with MODE high and chip select parked

  psram_pwr_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expired(t_expired)
  );

  psram_pwr_fsm #(
    .HOLD_CYC(HOLD_CYC), .SETTLE_CYC(SETTLE_CYC), .SHORT_CYC(SHORT_CYC), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .stby_req(stby_req),
    .stby_deep(stby_deep), .ret_sel(ret_sel), .expired(t_expired),
    .state(state), .load(t_load), .load_val(t_val), .ret_q(ret_q), .lost_q(lost_q)
  );

  always_comb begin
    mode_o      = !(state inside {SEQ_OFF, SEQ_HOLD, SEQ_DEEP});
    cs_force_hi = (state != SEQ_ACTIVE);
    ready       = (state == SEQ_ACTIVE);
    data_lost   = lost_q;
    keep_top    = keep_limit(ret_q);
    case (state)
      SEQ_ACTIVE:           dev_state = DEV_ACTIVE;
      SEQ_PARK, SEQ_LIGHT:  dev_state = DEV_STBY1;
      SEQ_DEEP:             dev_state = (ret_q == RET_NONE) ? DEV_STBY2_LOST : DEV_STBY2_KEEP;
      SEQ_WAKE:             dev_state = (ret_q == RET_NONE) ? DEV_INIT : DEV_STBY1;
      default:              dev_state = DEV_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     mh_cnt <= '0;
    else if (mode_o && cs_force_hi) mh_cnt <= (mh_cnt < MH_SAT) ? mh_cnt + 1'b1 : mh_cnt;
    else                            mh_cnt <= '0;
  end

  AST_MODE_FALL_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mode_o) && $past(pwr_good)) |-> ($past(cs_force_hi) && cs_force_hi)); // R3

  AST_MODE_RISE_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_o) |-> ($past(cs_force_hi) && cs_force_hi)); // R3

  AST_READY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mode_o && !cs_force_hi)); // R4

  AST_LOST_LONG_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ready) && data_lost) |-> (mh_cnt >= MH_SAT)); // R9

  AST_PWR_LOSS_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (!mode_o && !ready && cs_force_hi)); // R12

endmodule

// File: tb/psram_pwr_seq_bench.sv
module psram_pwr_seq_bench;
  localparam int T_HOLD = 12, T_SETTLE = 30, T_SHORT = 3;
  localparam int P_OFF = 0, P_HOLD = 1, P_SETTLE = 2, P_ACTIVE = 3,
                 P_PARK = 4, P_LIGHT = 5, P_DEEP = 6, P_WAKE = 7;

  logic clk = 1'b0, rst_n = 1'b0, pwr_good = 1'b0;
  logic stby_req = 1'b0, stby_deep = 1'b0;
  logic [1:0] ret_sel = 2'd0;
  logic mode_o, cs_force_hi, ready, data_lost;
  logic [2:0] dev_state;
  logic [20:0] keep_top;

  int checks = 0, fails = 0;
  bit started = 0;

  psram_pwr_seq #(.ADDR_W(21), .HOLD_CYC(T_HOLD), .SETTLE_CYC(T_SETTLE),
                  .SHORT_CYC(T_SHORT)) u_psram_pwr_seq (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .stby_req(stby_req),
    .stby_deep(stby_deep), .ret_sel(ret_sel), .mode_o(mode_o),
    .cs_force_hi(cs_force_hi), .ready(ready), .data_lost(data_lost),
    .dev_state(dev_state), .keep_top(keep_top)
  );

  always #4 clk = ~clk;

  // behavioural reference model
  int ph = P_OFF, rem = 0, m_ret = 0;
  bit m_deep = 0, m_lost = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = P_OFF; rem = 0; m_ret = 0; m_deep = 0; m_lost = 0;
    end else if (!pwr_good) begin
      ph = P_OFF; m_lost = 0;
    end else begin
      case (ph)
        P_OFF:    begin ph = P_HOLD; rem = T_HOLD; end
        P_HOLD:   begin rem--; if (rem == 0) begin ph = P_SETTLE; rem = T_SETTLE; end end
        P_SETTLE: begin rem--; if (rem == 0) ph = P_ACTIVE; end
        P_ACTIVE: if (stby_req) begin
                    ph = P_PARK; m_deep = stby_deep; m_ret = ret_sel; m_lost = 0;
                  end
        P_PARK:   ph = m_deep ? P_DEEP : P_LIGHT;
        P_LIGHT:  if (!stby_req) ph = P_ACTIVE;
        P_DEEP:   if (!stby_req) begin ph = P_WAKE; rem = (m_ret == 3) ? T_SETTLE : T_SHORT; end
        P_WAKE:   begin rem--; if (rem == 0) begin ph = P_ACTIVE; m_lost = (m_ret == 3); end end
        default:  ph = P_OFF;
      endcase
    end
  end

  function automatic string tag_of(int p, int r);
    case (p)
      P_OFF: return "R1";
      P_HOLD: return "R2";
      P_SETTLE: return "R4";
      P_ACTIVE, P_PARK: return "R5";
      P_LIGHT: return "R6";
      P_DEEP: return "R7";
      default: return (r == 3) ? "R9" : "R8";
    endcase
  endfunction

  function automatic logic [27:0] expect_vec(int p, int r, bit lost);
    logic m, c, rd;
    logic [2:0] s;
    logic [20:0] kt;
    m  = !(p == P_OFF || p == P_HOLD || p == P_DEEP);
    c  = (p != P_ACTIVE);
    rd = (p == P_ACTIVE);
    if (p == P_ACTIVE) s = 3'd1;
    else if (p == P_PARK || p == P_LIGHT) s = 3'd2;
    else if (p == P_DEEP) s = (r == 3) ? 3'd4 : 3'd3;
    else if (p == P_WAKE) s = (r == 3) ? 3'd0 : 3'd2;
    else s = 3'd0;
    kt = (r == 3) ? 21'd0 : (21'h1FFFFF >> (r + 1));
    return {m, c, rd, lost, s, kt};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  logic prev_mode = 1'b0, prev_cs = 1'b1;

  always @(negedge clk) begin
    if (rst_n && started) begin
      check(tag_of(ph, m_ret),
            32'({mode_o, cs_force_hi, ready, data_lost, dev_state, keep_top}),
            32'(expect_vec(ph, m_ret, m_lost)));
      if (mode_o !== prev_mode && ph != P_OFF)
        check("R3", 32'({prev_cs, cs_force_hi}), 32'b11);
      prev_mode = mode_o;
      prev_cs   = cs_force_hi;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ready(string tag);
    int n = 0;
    while (ready !== 1'b1 && n < 200) begin @(negedge clk); n++; end
    check(tag, 32'(ready), 32'd1);
  endtask

  task automatic deep_cycle(logic [1:0] r, logic [20:0] top, string tag);
    ret_sel = r; stby_deep = 1'b1; stby_req = 1'b1;
    step(5);
    check("R11", 32'(keep_top), 32'(top));
    stby_req = 1'b0;
    wait_ready(tag);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1; started = 1;
    step(2);
    check("R1", 32'({mode_o, cs_force_hi, ready, data_lost, dev_state}), 32'b0100_000);
    pwr_good = 1'b1;
    wait_ready("R4");
    step(2);
    // light standby
    stby_deep = 1'b0; stby_req = 1'b1;
    step(1);
    check("R5", 32'({ready, cs_force_hi, mode_o}), 32'b011);
    step(5);
    check("R6", 32'({mode_o, dev_state}), 32'b1_010);
    stby_req = 1'b0;
    step(1);
    check("R6", 32'(ready), 32'd1);
    // deep standby with each kept setting
    deep_cycle(2'd0, 21'h0FFFFF, "R8");
    deep_cycle(2'd1, 21'h07FFFF, "R8");
    // setting changes during standby are ignored
    ret_sel = 2'd2; stby_deep = 1'b1; stby_req = 1'b1;
    step(3);
    ret_sel = 2'd3;
    step(3);
    check("R10", 32'({keep_top, dev_state}), 32'({21'h03FFFF, 3'd3}));
    stby_req = 1'b0;
    step(T_SHORT + 1);
    check("R10", 32'({ready, data_lost}), 32'b10);
    // nothing kept
    deep_cycle(2'd3, 21'd0, "R9");
    check("R9", 32'(data_lost), 32'd1);
    stby_deep = 1'b0; stby_req = 1'b1;
    step(2);
    check("R9", 32'(data_lost), 32'd0);
    stby_req = 1'b0;
    wait_ready("R6");
    // one-cycle deep request released during park
    ret_sel = 2'd1; stby_deep = 1'b1; stby_req = 1'b1;
    step(1);
    stby_req = 1'b0;
    step(1);
    check("R7", 32'({mode_o, dev_state}), 32'b0_011);
    wait_ready("R8");
    // power glitch
    step(3);
    pwr_good = 1'b0;
    step(1);
    check("R12", 32'({mode_o, cs_force_hi, ready, dev_state}), 32'b010_000);
    pwr_good = 1'b1;
    step(T_HOLD);
    check("R2", 32'(mode_o), 32'd0);
    wait_ready("R12");
    step(3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=%0d cycles expected=<20000", 20000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule